// File: doc/BRIEF.md
# Exception pending control register

This block is one 32-bit memory-mapped word in an interrupt controller. Software uses it to raise or withdraw pending requests for three system exceptions: the non-maskable interrupt, a deferred service-call exception and a system-tick exception. The same word reports controller status that is produced elsewhere and passed in on input pins. That status is the number of the active exception, the number of the highest-priority pending exception, whether any ordinary interrupt is pending, whether only one handler is active, and a debug-only interrupt flag.

Each pending flag is driven out to the controller. Software writes a 1 to a set bit or a clear bit to change a flag. The controller clears a flag by pulsing its handler-entry acknowledge. A flag cannot be set by any other means.

Only privileged software may access the word. An unprivileged access does not change any state and reads back zero. It also returns a one-cycle bus error.

Top module: `excp_pend_reg`

## Requirements
- R1: After reset, all three pending outputs, `conflict_err` and `bus_err` are 0, and every stored bit of the word reads 0.
- R2: A privileged write to the register address with bit 31 = 1 sets `nmi_pend` at the next clock edge. A pulse on `ack_nmi` clears it at the next edge. No write bit clears it.
- R3: A privileged write with bit 28 = 1 sets `svc_pend`. A privileged write with bit 27 = 1 clears it. A pulse on `ack_svc` also clears it.
- R4: A privileged write with bit 26 = 1 sets `tick_pend`. A privileged write with bit 25 = 1 clears it. A pulse on `ack_tick` also clears it.
- R5: A write with both bits of one pair set (28 and 27, or 26 and 25) clears that flag. It also sets `conflict_err`, which stays at 1 until reset.
- R6: When a software set and a handler-entry acknowledge for the same flag arrive in the same cycle, the flag ends up set.
- R7: A privileged read returns three pending flags: NMI at bit 31, service at bit 28 and tick at bit 26. The write-only bits 27 and 25 read 0, and the reserved bits 30, 29, 24, 21, 20, 10, 9 and 8 read 0. `bus_rdata` is 0 whenever no privileged read of the register address is in progress; a read is `bus_en`=1 with `bus_wr`=0.
- R8: On a read, bit 23 equals `st_dbg_isr` only while `st_dbg_mode` = 1 and is 0 otherwise. Bit 22 equals `st_irq_pend`, and bits 19:12 carry `st_pend_vec`.
- R9: On a read, bits 7:0 carry `st_active`. Bit 11 equals `st_ret_base` when `st_active` is non-zero and reads 0 when it is zero.
- R10: An access to the register address with `bus_priv` = 0 leaves all flags unchanged and reads 0. It also raises `bus_err` for exactly the following cycle.
- R11: A write to any other address has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access comes from privileged software |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Error response, one cycle after an unprivileged access |
| st_active | input | VEC_W | Active exception number, 0 in thread mode |
| st_pend_vec | input | VEC_W | Highest-priority pending enabled exception number (already masked) |
| st_irq_pend | input | 1 | Some interrupt other than NMI or a fault is pending |
| st_ret_base | input | 1 | Only one exception is active |
| st_dbg_mode | input | 1 | Processor is halted in debug |
| st_dbg_isr | input | 1 | Debug interrupt status |
| ack_nmi | input | 1 | NMI handler entry |
| ack_svc | input | 1 | Service-call handler entry |
| ack_tick | input | 1 | System-tick handler entry |
| nmi_pend | output | 1 | NMI pending |
| svc_pend | output | 1 | Service-call pending |
| tick_pend | output | 1 | System-tick pending |
| conflict_err | output | 1 | Sticky: a set and a clear bit of one pair were written together |

## Verification
Two events can land on the same flag in the same cycle: a software write through the bus and a handler-entry acknowledge from the controller. A third overlap is a set bit and a clear bit written together in one word. Directed steps produce each overlap on purpose, with an acknowledge pulsed in the same cycle as a set write and with a write that carries both bits of a pair. A randomized phase then drives writes and acknowledges freely so that they often coincide. A behavioural model in the bench applies the priority order (conflicting clear, then set, then clear or acknowledge) and compares every pending flag, the error outputs and the read word on every clock.

// File: rtl/excp_pend_pkg.sv
package excp_pend_pkg;

   localparam int DATA_W  = 32;
   localparam int FIELD_W = 8;
   localparam int NUM_EX  = 3;

   // bit positions the controller and software decode
   localparam int B_NMI_SET  = 31;
   localparam int B_SVC_SET  = 28;
   localparam int B_SVC_CLR  = 27;
   localparam int B_TICK_SET = 26;
   localparam int B_TICK_CLR = 25;
   localparam int B_DBG      = 23;
   localparam int B_IRQP     = 22;
   localparam int B_PVEC_LO  = 12;
   localparam int B_RETB     = 11;
   localparam int B_AVEC_LO  = 0;

   typedef enum int {EX_NMI = 0, EX_SVC = 1, EX_TICK = 2} ex_id_e;

   function automatic int set_bit(input int ex);
      case (ex)
         EX_NMI:  return B_NMI_SET;
         EX_SVC:  return B_SVC_SET;
         default: return B_TICK_SET;
      endcase
   endfunction

   // -1 marks a flag without a software clear bit
   function automatic int clr_bit(input int ex);
      case (ex)
         EX_NMI:  return -1;
         EX_SVC:  return B_SVC_CLR;
         default: return B_TICK_CLR;
      endcase
   endfunction

endpackage

// File: rtl/excp_pend_cell.sv
module excp_pend_cell #(
   parameter bit HAS_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic ack_i,
   output logic pend_o,
   output logic conflict_o
);

   logic drop;
   logic pend_q;

   generate
      if (HAS_CLR) begin : g_pair
         assign conflict_o = set_i & clr_i;
         assign drop       = clr_i | ack_i;
      end else begin : g_setonly
         assign conflict_o = 1'b0;
         assign drop       = ack_i | clr_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (conflict_o) pend_q <= 1'b0;
      else if (set_i)      pend_q <= 1'b1;
      else if (drop)       pend_q <= 1'b0;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/excp_pend_bus.sv
module excp_pend_bus #(
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] REG_OFFSET = 32'h0000_0D04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic              priv_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_ok_o,
   output logic              rd_ok_o,
   output logic              err_o
);

   localparam logic [ADDR_W-1:0] MY_ADDR = REG_OFFSET[ADDR_W-1:0];

   generate
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_aw
         $error("excp_pend_bus: ADDR_W out of range");
      end
      if (REG_OFFSET[1:0] != 2'b00) begin : g_bad_align
         $error("excp_pend_bus: REG_OFFSET not word aligned");
      end
      if (ADDR_W < 32) begin : g_fit
         if ((REG_OFFSET >> ADDR_W) != 0) begin : g_bad_fit
            $error("excp_pend_bus: REG_OFFSET does not fit ADDR_W");
         end
      end
   endgenerate

   logic hit;
   logic err_q;

   assign hit     = en_i && (addr_i == MY_ADDR);
   assign wr_ok_o = hit && wr_i && priv_i;
   assign rd_ok_o = hit && !wr_i && priv_i;

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= hit && !priv_i;
   end

   assign err_o = err_q;

endmodule

// File: rtl/excp_pend_rdmux.sv
module excp_pend_rdmux
   import excp_pend_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic              rd_ok_i,
   input  logic [NUM_EX-1:0] pend_i,
   input  logic [VEC_W-1:0]  active_i,
   input  logic [VEC_W-1:0]  pvec_i,
   input  logic              irq_pend_i,
   input  logic              ret_base_i,
   input  logic              dbg_mode_i,
   input  logic              dbg_isr_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [FIELD_W-1:0] act_f;
   logic [FIELD_W-1:0] pvec_f;
   logic               in_handler;
   logic [DATA_W-1:0]  word;

   always_comb begin
      act_f  = '0;
      pvec_f = '0;
      act_f[VEC_W-1:0]  = active_i;
      pvec_f[VEC_W-1:0] = pvec_i;
   end

   assign in_handler = |active_i;

   always_comb begin
      word = '0;
      for (int e = 0; e < NUM_EX; e++) begin
         word[set_bit(e)] = pend_i[e];
      end
      word[B_DBG]                       = dbg_mode_i & dbg_isr_i;
      word[B_IRQP]                      = irq_pend_i;
      word[B_PVEC_LO +: FIELD_W]        = pvec_f;
      word[B_RETB]                      = in_handler & ret_base_i;
      word[B_AVEC_LO +: FIELD_W]        = act_f;
   end

   assign rdata_o = rd_ok_i ? word : '0;

endmodule

// File: rtl/excp_pend_reg.sv
module excp_pend_reg
   import excp_pend_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] REG_OFFSET = 32'h0000_0D04,
   parameter int          VEC_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic              bus_priv,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   input  logic [VEC_W-1:0]  st_active,
   input  logic [VEC_W-1:0]  st_pend_vec,
   input  logic              st_irq_pend,
   input  logic              st_ret_base,
   input  logic              st_dbg_mode,
   input  logic              st_dbg_isr,
   input  logic              ack_nmi,
   input  logic              ack_svc,
   input  logic              ack_tick,
   output logic              nmi_pend,
   output logic              svc_pend,
   output logic              tick_pend,
   output logic              conflict_err
);

   generate
      if (VEC_W < 1 || VEC_W > FIELD_W) begin : g_bad_vw
         $error("excp_pend_reg: VEC_W must be 1..8");
      end
   endgenerate

   logic              wr_ok;
   logic              rd_ok;
   logic [NUM_EX-1:0] ack_v;
   logic [NUM_EX-1:0] pend_v;
   logic [NUM_EX-1:0] conf_v;
   logic              conf_q;
   logic              unused_wbits;

   excp_pend_bus #(
      .ADDR_W     (ADDR_W),
      .REG_OFFSET (REG_OFFSET)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (bus_en),
      .wr_i    (bus_wr),
      .priv_i  (bus_priv),
      .addr_i  (bus_addr),
      .wr_ok_o (wr_ok),
      .rd_ok_o (rd_ok),
      .err_o   (bus_err)
   );

   assign ack_v[EX_NMI]  = ack_nmi;
   assign ack_v[EX_SVC]  = ack_svc;
   assign ack_v[EX_TICK] = ack_tick;

   generate
      for (genvar g = 0; g < NUM_EX; g++) begin : g_cell
         localparam int  SB  = set_bit(g);
         localparam int  CB  = clr_bit(g);
         localparam bit  HC  = (CB >= 0);
         logic clr_s;
         if (HC) begin : g_clr
            assign clr_s = wr_ok & bus_wdata[CB];
         end else begin : g_noclr
            assign clr_s = 1'b0;
         end
         excp_pend_cell #(.HAS_CLR(HC)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (wr_ok & bus_wdata[SB]),
            .clr_i      (clr_s),
            .ack_i      (ack_v[g]),
            .pend_o     (pend_v[g]),
            .conflict_o (conf_v[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       conf_q <= 1'b0;
      else if (|conf_v) conf_q <= 1'b1;
   end

   assign unused_wbits = ^{bus_wdata[30:29], bus_wdata[24:0]};

   excp_pend_rdmux #(.VEC_W(VEC_W)) u_rd (
      .rd_ok_i    (rd_ok),
      .pend_i     (pend_v),
      .active_i   (st_active),
      .pvec_i     (st_pend_vec),
      .irq_pend_i (st_irq_pend),
      .ret_base_i (st_ret_base),
      .dbg_mode_i (st_dbg_mode),
      .dbg_isr_i  (st_dbg_isr),
      .rdata_o    (bus_rdata)
   );

   assign nmi_pend     = pend_v[EX_NMI];
   assign svc_pend     = pend_v[EX_SVC];
   assign tick_pend    = pend_v[EX_TICK];
   assign conflict_err = conf_q;

endmodule

// File: rtl/excp_pend_chk.sv
module excp_pend_chk #(
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] REG_OFFSET = 32'h0000_0D04,
   parameter int          VEC_W      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_wr,
   input logic              bus_priv,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              bus_err,
   input logic [VEC_W-1:0]  st_active,
   input logic              ack_nmi,
   input logic              ack_svc,
   input logic              nmi_pend,
   input logic              svc_pend,
   input logic              tick_pend,
   input logic              conflict_err
);

   logic at_reg;
   logic pw;

   assign at_reg = bus_en && (bus_addr == REG_OFFSET[ADDR_W-1:0]);
   assign pw     = at_reg && bus_wr && bus_priv;

   // R2
   nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw && bus_wdata[31] |=> nmi_pend);

   // R2
   nmi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_nmi && !(pw && bus_wdata[31]) |=> !nmi_pend);

   // R3
   svc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw && bus_wdata[27] |=> !svc_pend);

   // R6
   svc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw && bus_wdata[28] && !bus_wdata[27] && ack_svc |=> svc_pend);

   // R4
   tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw && bus_wdata[26] && !bus_wdata[25] |=> tick_pend);

   // R5
   conflict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_err |=> conflict_err);

   // R5
   conflict_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw && bus_wdata[26] && bus_wdata[25] |=> conflict_err && !tick_pend);

   // R10
   unpriv_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_reg && !bus_priv |=> bus_err);

   // R10
   unpriv_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_priv |-> bus_rdata == 32'h0);

   // R7
   wronly_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[27] == 1'b0 && bus_rdata[25] == 1'b0 && bus_rdata[30:29] == 2'b00
      && bus_rdata[24] == 1'b0 && bus_rdata[21:20] == 2'b00 && bus_rdata[10:8] == 3'b000);

   // R9
   retbase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[11] |-> st_active != '0);

endmodule

bind excp_pend_reg excp_pend_chk #(
   .ADDR_W     (ADDR_W),
   .REG_OFFSET (REG_OFFSET),
   .VEC_W      (VEC_W)
) u_chk (.*);

// File: tb/excp_pend_reg_test.sv
module excp_pend_reg_test;

   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 12;
   localparam logic [31:0] OFF        = 32'h0000_0D04;
   localparam int          VW         = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_en, bus_wr, bus_priv;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_wdata, bus_rdata;
   logic          bus_err;
   logic [VW-1:0] st_active, st_pend_vec;
   logic          st_irq_pend, st_ret_base, st_dbg_mode, st_dbg_isr;
   logic          ack_nmi, ack_svc, ack_tick;
   logic          nmi_pend, svc_pend, tick_pend, conflict_err;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   bit  m_nmi, m_svc, m_tick, m_conf, m_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   excp_pend_reg #(.ADDR_W(AW), .REG_OFFSET(OFF), .VEC_W(VW)) uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_rd();
      logic [31:0] w;
      w = '0;
      if (bus_en && !bus_wr && bus_priv && bus_addr == OFF[AW-1:0]) begin
         w[31]    = m_nmi;
         w[28]    = m_svc;
         w[26]    = m_tick;
         w[23]    = st_dbg_mode & st_dbg_isr;
         w[22]    = st_irq_pend;
         w[19:12] = st_pend_vec;
         w[11]    = (st_active != 0) & st_ret_base;
         w[7:0]   = st_active;
      end
      return w;
   endfunction

   task automatic model_update();
      bit hit, pw, s, c;
      if (!rst_n) begin
         m_nmi = 0; m_svc = 0; m_tick = 0; m_conf = 0; m_err = 0;
         return;
      end
      hit = bus_en && bus_addr == OFF[AW-1:0];
      pw  = hit && bus_wr && bus_priv;
      m_err = hit && !bus_priv;
      if (pw && bus_wdata[31]) m_nmi = 1; else if (ack_nmi) m_nmi = 0;
      s = pw && bus_wdata[28]; c = pw && bus_wdata[27];
      if (s && c) begin m_svc = 0; m_conf = 1; end
      else if (s) m_svc = 1;
      else if (c || ack_svc) m_svc = 0;
      s = pw && bus_wdata[26]; c = pw && bus_wdata[25];
      if (s && c) begin m_tick = 0; m_conf = 1; end
      else if (s) m_tick = 1;
      else if (c || ack_tick) m_tick = 0;
   endtask

   // one clock: combinational read check, edge, registered compare
   task automatic cyc();
      #1;
      chk("R7 rdata", bus_rdata, model_rd());
      @(posedge clk);
      model_update();
      @(negedge clk);
      chk("R2 nmi_pend", {31'b0, nmi_pend}, {31'b0, m_nmi});
      chk("R3 svc_pend", {31'b0, svc_pend}, {31'b0, m_svc});
      chk("R4 tick_pend", {31'b0, tick_pend}, {31'b0, m_tick});
      chk("R5 conflict_err", {31'b0, conflict_err}, {31'b0, m_conf});
      chk("R10 bus_err", {31'b0, bus_err}, {31'b0, m_err});
   endtask

   task automatic idle();
      bus_en = 0; bus_wr = 0; bus_priv = 1; bus_addr = OFF[AW-1:0]; bus_wdata = '0;
      ack_nmi = 0; ack_svc = 0; ack_tick = 0;
   endtask

   task automatic wr(input logic [31:0] d, input bit priv = 1'b1);
      idle(); bus_en = 1; bus_wr = 1; bus_priv = priv; bus_wdata = d;
   endtask

   task automatic rd(input bit priv = 1'b1);
      idle(); bus_en = 1; bus_priv = priv;
   endtask

   initial begin
      rst_n = 0; idle();
      st_active = '0; st_pend_vec = '0; st_irq_pend = 0; st_ret_base = 0;
      st_dbg_mode = 0; st_dbg_isr = 0;
      repeat (3) cyc();
      // R1: reset state
      chk("R1 nmi", {31'b0, nmi_pend}, 0);
      chk("R1 conflict", {31'b0, conflict_err}, 0);
      rst_n = 1;
      rd(); #1; chk("R1 read zero", bus_rdata, 32'h0); cyc();

      // R2: NMI set, read, acknowledge, set wins over ack (R6)
      wr(32'h8000_0000); cyc();
      chk("R2 set", {31'b0, nmi_pend}, 1);
      rd(); #1; chk("R7 nmi readback", bus_rdata, 32'h8000_0000); cyc();
      idle(); ack_nmi = 1; cyc();
      chk("R2 ack clears", {31'b0, nmi_pend}, 0);
      wr(32'h8000_0000); ack_nmi = 1; cyc();
      chk("R6 nmi set beats ack", {31'b0, nmi_pend}, 1);

      // R3: service-call
      wr(32'h1000_0000); cyc();
      chk("R3 set", {31'b0, svc_pend}, 1);
      wr(32'h0800_0000); cyc();
      chk("R3 clear", {31'b0, svc_pend}, 0);
      wr(32'h1000_0000); ack_svc = 1; cyc();
      chk("R6 svc set beats ack", {31'b0, svc_pend}, 1);
      idle(); ack_svc = 1; cyc();
      chk("R3 ack clears", {31'b0, svc_pend}, 0);

      // R4: system tick, write-only bits read zero
      wr(32'h0400_0000); cyc();
      chk("R4 set", {31'b0, tick_pend}, 1);
      rd(); #1; chk("R7 tick readback", bus_rdata, 32'h8400_0000); cyc();
      wr(32'h0200_0000); cyc();
      chk("R4 clear", {31'b0, tick_pend}, 0);

      // R5: set and clear together
      wr(32'h1000_0000); cyc();
      wr(32'h1800_0000); cyc();
      chk("R5 clear wins", {31'b0, svc_pend}, 0);
      chk("R5 sticky raised", {31'b0, conflict_err}, 1);
      idle(); repeat (3) cyc();
      chk("R5 sticky held", {31'b0, conflict_err}, 1);

      // R8 / R9: status fields
      st_dbg_isr = 1; st_dbg_mode = 0; st_irq_pend = 1; st_pend_vec = 8'h5A;
      st_ret_base = 1; st_active = '0;
      rd(); #1; chk("R8 R9 thread mode", bus_rdata, 32'h8045_A000); cyc();
      st_dbg_mode = 1; st_active = 8'h13;
      rd(); #1; chk("R8 R9 in handler", bus_rdata, 32'h80C5_A813); cyc();

      // R10: unprivileged access
      wr(32'h0400_0000, 1'b0); cyc();
      chk("R10 write ignored", {31'b0, tick_pend}, 0);
      chk("R10 error pulse", {31'b0, bus_err}, 1);
      rd(1'b0); #1; chk("R10 read zero", bus_rdata, 32'h0); cyc();
      idle(); cyc();
      chk("R10 error one cycle", {31'b0, bus_err}, 0);

      // R11: other address
      wr(32'h1400_0000); bus_addr = OFF[AW-1:0] + 12'd4; cyc();
      chk("R11 other addr svc", {31'b0, svc_pend}, 0);
      chk("R11 other addr tick", {31'b0, tick_pend}, 0);

      // randomized overlap of writes and acknowledges, model compared each clock
      for (int i = 0; i < 3000; i++) begin
         idle();
         bus_en    = ($urandom_range(0, 3) != 0);
         bus_wr    = $urandom_range(0, 1);
         bus_priv  = ($urandom_range(0, 7) != 0);
         bus_addr  = ($urandom_range(0, 7) != 0) ? OFF[AW-1:0] : OFF[AW-1:0] + 12'd8;
         bus_wdata = $urandom;
         ack_nmi   = $urandom_range(0, 1);
         ack_svc   = $urandom_range(0, 1);
         ack_tick  = $urandom_range(0, 1);
         st_active = $urandom_range(0, 3) == 0 ? 8'h00 : 8'($urandom);
         st_pend_vec = 8'($urandom);
         {st_irq_pend, st_ret_base, st_dbg_mode, st_dbg_isr} = 4'($urandom);
         if (i == 1500) rst_n = 0;
         if (i == 1503) rst_n = 1;
         cyc();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule